// File: doc/BRIEF.md
# SAR Conversion Timer with Early Interrupt

This block paces a single successive-approximation conversion. The analog comparator and the bit-by-bit result register live elsewhere. Here they are represented only by the number of converter clocks a conversion takes. The converter clock arrives as an enable (`cnvEn`) on the system clock. Only cycles with the enable high move the conversion forward.

A one-cycle `start` pulse begins a conversion. At that moment the block captures the resolution, the early-interrupt select, the override bit, the channel index and both interrupt masks. It then holds `busy` high while it counts the converter clocks for the captured resolution, and pulses `eoc` once the last one has gone by.

The interrupt output gives downstream logic a head start. Normally it pulses a selectable number of converter clocks before the result is ready, so the service routine can already be running when the data lands. With the override bit set, the interrupt is instead raised together with `eoc` and is gated by the other mask. If the select value is too large for the chosen resolution, it is reduced to the largest value that resolution allows.

Top module: `sarConvTimer`

## Requirements
- R1: `resSel` encodes the resolution: 0 is 6 bits, 1 is 8 bits, 2 is 10 bits and 3 is 12 bits. A start accepted while idle raises `busy` in the next cycle. The conversion then lasts resolution+2 enabled converter clocks, and `busy` falls right after the last of them.
- R2: A system clock cycle with `cnvEn` low does not advance the conversion, and `busy` stays high through it.
- R3: `eoc` is high for exactly one cycle: the cycle right after the last converter clock. `busy` is low in that cycle.
- R4: With override clear, the select value k (0 to 7) makes `irq` pulse for one cycle when k+1 enabled converter clocks of the conversion remain.
- R5: The largest legal select value is 3 at 6 bits and 5 at 8 bits. At 10 and 12 bits all eight values are legal. A larger select value behaves exactly like the largest legal one.
- R6: With override clear, `irq` is gated by `earlyMask[chanSel]`. With override set, `irq` pulses in the same cycle as `eoc` and is gated by `globalMask[chanSel]`. At most one `irq` pulse occurs per conversion.
- R7: A `start` pulse while `busy` is high is ignored. It changes neither the length nor the interrupt timing of the running conversion.
- R8: Resolution, select, override, channel and both masks are sampled only when a start is accepted. Changing them during a conversion has no effect on it.
- R9: While reset is asserted and right after it, `busy`, `eoc` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cnvEn | input | 1 | Converter clock enable, one system cycle per converter clock |
| start | input | 1 | Start pulse, taken only while idle |
| resSel | input | 2 | Resolution select: 0=6, 1=8, 2=10, 3=12 bits |
| eisSel | input | 3 | Early interrupt select k, lead of k+1 converter clocks |
| override | input | 1 | 1: interrupt at end of conversion, gated by the global mask |
| chanSel | input | CH_W | Channel whose mask bits gate the interrupt |
| globalMask | input | NUM_CH | Per-channel enable used when override is set |
| earlyMask | input | NUM_CH | Per-channel enable used when override is clear |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| irq | output | 1 | One-cycle data-ready interrupt pulse |

## Verification
Every resolution is run with every select value, under two converter enables. One holds the enable high continuously and the other leaves gaps. Together they separate counting system clocks from counting converter clocks, and they expose the clamp at the 6-bit and 8-bit boundaries.

The override and mask combinations are run both enabled and blocked, which shows that each mode uses its own mask and its own timing. Further runs pulse start during a conversion, change every setting mid-conversion, and start again in the `eoc` cycle. These show that only settings captured at an accepted start matter.

// File: rtl/sarTimerPkg.sv
package sarTimerPkg;
  // Longest conversion: 12 bits plus two extra converter clocks.
  localparam int MIN_BITS = 6;
  localparam int BIT_STEP = 2;
  localparam int EXTRA_CLK = 2;
  localparam int MAX_LEN = MIN_BITS + 3 * BIT_STEP + EXTRA_CLK;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    RES_6 = 2'd0,
    RES_8 = 2'd1,
    RES_10 = 2'd2,
    RES_12 = 2'd3
  } resT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // accepted start, capture settings
    logic tick;   // one converter clock consumed
  } strobeT;

  // Number of converter clocks a conversion takes at resolution r.
  function automatic logic [LEN_W-1:0] convLen(input logic [1:0] r);
    return LEN_W'(MIN_BITS + EXTRA_CLK) + LEN_W'({r, 1'b0});
  endfunction

  // Largest legal early select at resolution r.
  function automatic logic [SEL_W-1:0] selLimit(input logic [1:0] r);
    logic [SEL_W-1:0] lim;
    case (resT'(r))
      RES_6:   lim = 3'd3;
      RES_8:   lim = 3'd5;
      default: lim = 3'd7;
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/sarTimerCtrl.sv
module sarTimerCtrl
  import sarTimerPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cnvEn,
  input  logic   lastTick,
  output strobeT strobe,
  output logic   busy
);
  typedef enum logic {ST_IDLE, ST_CONV} stateT;
  stateT state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext = ST_CONV;
        end
      end
      ST_CONV: begin
        // start is deliberately not looked at here
        strobe.tick = cnvEn;
        if (lastTick) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_CONV);
endmodule

// File: rtl/sarTimerDp.sv
module sarTimerDp
  import sarTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [1:0]        resSel,
  input  logic [SEL_W-1:0]  eisSel,
  input  logic              override,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [NUM_CH-1:0] globalMask,
  input  logic [NUM_CH-1:0] earlyMask,
  output logic              lastTick,
  output logic              eoc,
  output logic              irq
);
  logic [LEN_W-1:0] tickCnt;
  logic [LEN_W-1:0] lastPosQ;
  logic [LEN_W-1:0] earlyPosQ;
  logic             ovrQ;
  logic             gateQ;

  // Settings decoded at start.
  logic [SEL_W-1:0] selLim, selEff;
  logic [LEN_W-1:0] lenIn, earlyIn;
  logic             gateIn;

  assign selLim = selLimit(resSel);
  assign selEff = (eisSel > selLim) ? selLim : eisSel;
  assign lenIn = convLen(resSel);
  // Early pulse after count reaches len-(k+1): compare before increment.
  assign earlyIn = lenIn - LEN_W'(2) - LEN_W'(selEff);

  // Mask bit picked by the mode in force at start.
  logic [NUM_CH-1:0] maskSel;
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gMask
      assign maskSel[c] = override ? globalMask[c] : earlyMask[c];
    end
  endgenerate
  assign gateIn = maskSel[chanSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPosQ <= '0;
      earlyPosQ <= '0;
      ovrQ <= 1'b0;
      gateQ <= 1'b0;
    end else if (strobe.load) begin
      lastPosQ <= lenIn - LEN_W'(1);
      earlyPosQ <= earlyIn;
      ovrQ <= override;
      gateQ <= gateIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (strobe.load) tickCnt <= '0;
    else if (strobe.tick) tickCnt <= tickCnt + LEN_W'(1);
  end

  logic earlyHit;
  assign lastTick = strobe.tick && (tickCnt == lastPosQ);
  assign earlyHit = strobe.tick && (tickCnt == earlyPosQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eoc <= 1'b0;
      irq <= 1'b0;
    end else begin
      eoc <= lastTick;
      irq <= gateQ && (ovrQ ? lastTick : earlyHit);
    end
  end
endmodule

// File: rtl/sarConvTimer.sv
module sarConvTimer
  import sarTimerPkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvEn,
  input  logic              start,
  input  logic [1:0]        resSel,
  input  logic [SEL_W-1:0]  eisSel,
  input  logic              override,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [NUM_CH-1:0] globalMask,
  input  logic [NUM_CH-1:0] earlyMask,
  output logic              busy,
  output logic              eoc,
  output logic              irq
);
  strobeT strobe;
  logic   lastTick;

  sarTimerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cnvEn(cnvEn),
    .lastTick(lastTick), .strobe(strobe), .busy(busy)
  );

  sarTimerDp #(.NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resSel(resSel),
    .eisSel(eisSel), .override(override), .chanSel(chanSel),
    .globalMask(globalMask), .earlyMask(earlyMask),
    .lastTick(lastTick), .eoc(eoc), .irq(irq)
  );
endmodule

// File: rtl/sarTimerCheck.sv
module sarTimerCheck (
  input logic       clk,
  input logic       rstN,
  input logic       cnvEn,
  input logic       start,
  input logic [1:0] resSel,
  input logic       busy,
  input logic       eoc,
  input logic       irq
);
  logic [4:0] seenTicks;
  logic [4:0] wantTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenTicks <= '0;
      wantTicks <= '0;
    end else if (start && !busy) begin
      seenTicks <= '0;
      wantTicks <= 5'd8 + {2'b0, resSel, 1'b0};
    end else if (busy && cnvEn) begin
      seenTicks <= seenTicks + 5'd1;
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R1
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    eoc |-> (seenTicks == wantTicks)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cnvEn) |=> busy); // R2
  AST_EOC_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eoc |-> (!busy && $past(busy))); // R3
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eoc |=> !eoc); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R4
  AST_IRQ_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (busy || eoc)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || eoc)); // R7
endmodule

bind sarConvTimer sarTimerCheck uChk (
  .clk(clk), .rstN(rstN), .cnvEn(cnvEn), .start(start), .resSel(resSel),
  .busy(busy), .eoc(eoc), .irq(irq)
);

// File: tb/sarConvTimer_test.sv
`timescale 1ns/100ps
module sarConvTimer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cnvEn = 1'b1;
  logic       start = 1'b0;
  logic [1:0] resSel = '0;
  logic [2:0] eisSel = '0;
  logic       override = 1'b0;
  logic [1:0] chanSel = '0;
  logic [3:0] globalMask = '0;
  logic [3:0] earlyMask = '0;
  logic       busy, eoc, irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int enMode = 0;

  sarConvTimer #(.NUM_CH(4)) uut (
    .clk(clk), .rstN(rstN), .cnvEn(cnvEn), .start(start), .resSel(resSel),
    .eisSel(eisSel), .override(override), .chanSel(chanSel),
    .globalMask(globalMask), .earlyMask(earlyMask),
    .busy(busy), .eoc(eoc), .irq(irq)
  );

  always #2 clk = ~clk; // 250 MHz

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Converter enable pattern: steady, or with gaps.
  always @(negedge clk) cnvEn <= (enMode == 0) ? 1'b1 : ((cyc % 3) != 2);

  // Behavioural reference model.
  bit mBusy = 0, mEoc = 0, mIrq = 0, mOvr = 0, mGate = 0;
  int mT = 0, mL = 0, mN = 0;
  always @(posedge clk) begin
    int lim;
    cyc++;
    if (!rstN) begin
      mBusy = 0; mEoc = 0; mIrq = 0; mT = 0;
    end else begin
      mEoc = 0; mIrq = 0;
      if (!mBusy) begin
        if (start) begin
          mBusy = 1; mT = 0;
          mL = 6 + 2 * int'(resSel) + 2;
          lim = (resSel == 0) ? 3 : (resSel == 1) ? 5 : 7;
          mN = ((int'(eisSel) > lim) ? lim : int'(eisSel)) + 1;
          mOvr = override;
          mGate = override ? globalMask[chanSel] : earlyMask[chanSel];
        end
      end else if (cnvEn) begin
        mT++;
        if (mT == mL) begin
          mBusy = 0; mEoc = 1; mIrq = mOvr && mGate;
        end else if (mT == mL - mN) begin
          mIrq = !mOvr && mGate;
        end
      end
    end
  end

  // Tick counters for the directed checks.
  int convTicks = 0, leadTicks = 0, irqCnt = 0;
  bit irqSeen = 0, eocSeen = 0;
  always @(posedge clk) begin
    if (busy && cnvEn) begin
      convTicks++;
      if (irqSeen) leadTicks++;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == mBusy, "R1", "busy", busy, mBusy);
      chk(eoc == mEoc, "R3", "eoc", eoc, mEoc);
      chk(irq == mIrq, "R4", "irq", irq, mIrq);
      if (irq) begin irqSeen = 1; irqCnt++; end
      if (eoc) eocSeen = 1;
    end
  end

  task automatic doConv(input int res, input int k, input bit ovr, input int ch,
                        input logic [3:0] gm, input logic [3:0] em,
                        input bit immediate, input bit midChange,
                        input bit startBusy, input string tag);
    int len, lim, n, expIrq;
    if (!immediate) begin @(negedge clk); #1; end
    resSel = 2'(res); eisSel = 3'(k); override = ovr; chanSel = 2'(ch);
    globalMask = gm; earlyMask = em; start = 1'b1;
    convTicks = 0; leadTicks = 0; irqCnt = 0; irqSeen = 0; eocSeen = 0;
    @(negedge clk); #1;
    start = 1'b0;
    if (midChange) begin
      resSel = ~resSel; eisSel = ~eisSel; override = ~override;
      chanSel = chanSel + 2'd1; globalMask = ~gm; earlyMask = ~em;
    end
    while (!eocSeen) begin
      @(negedge clk); #1;
      start = startBusy && busy;
    end
    start = 1'b0;
    len = 6 + 2 * res + 2;
    lim = (res == 0) ? 3 : (res == 1) ? 5 : 7;
    n = ((k > lim) ? lim : k) + 1;
    expIrq = (ovr ? gm[ch] : em[ch]) ? 1 : 0;
    chk(convTicks == len, tag, "converter clocks per conversion", convTicks, len);
    chk(irqCnt == expIrq, tag, "irq pulses per conversion", irqCnt, expIrq);
    if (expIrq == 1)
      chk(leadTicks == (ovr ? 0 : n), tag, "irq lead in converter clocks",
          leadTicks, ovr ? 0 : n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 0, "R9", "busy in reset", busy, 0);
    chk(eoc == 0, "R9", "eoc in reset", eoc, 0);
    chk(irq == 0, "R9", "irq in reset", irq, 0);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && eoc == 0 && irq == 0, "R9", "outputs after reset",
        {busy, eoc, irq}, 0);

    // R1 R4 R5: every resolution with every select, steady enable
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++)
        doConv(r, k, 0, r, 4'h0, 4'hF, 0, 0, 0,
               (k > ((r == 0) ? 3 : (r == 1) ? 5 : 7)) ? "R5" : "R4");

    // R2: gaps in the converter enable
    enMode = 1;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++)
        doConv(r, k, 0, 3 - r, 4'h0, 4'hF, 0, 0, 0, "R2");

    // R6: override and mask gating
    enMode = 0;
    doConv(3, 4, 1, 2, 4'h4, 4'h0, 0, 0, 0, "R6"); // override, global on
    doConv(3, 4, 1, 2, 4'hB, 4'hF, 0, 0, 0, "R6"); // override, global off
    doConv(1, 2, 0, 1, 4'hF, 4'hD, 0, 0, 0, "R6"); // early mask off
    enMode = 1;
    doConv(0, 7, 1, 0, 4'h1, 4'h0, 0, 0, 0, "R6");

    // R7: start held while busy
    doConv(2, 3, 0, 0, 4'h0, 4'h1, 0, 0, 1, "R7");
    enMode = 0;
    doConv(0, 1, 1, 3, 4'h8, 4'h0, 0, 0, 1, "R7");

    // R8: settings changed mid-conversion
    doConv(0, 2, 0, 1, 4'h0, 4'h2, 0, 1, 0, "R8");
    doConv(3, 7, 1, 2, 4'h4, 4'h0, 0, 1, 0, "R8");

    // R3: restart in the eoc cycle
    doConv(1, 5, 0, 0, 4'h0, 4'h1, 0, 0, 0, "R3");
    doConv(2, 0, 0, 0, 4'h0, 4'h1, 1, 0, 0, "R3");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule